// File: doc/BRIEF.md
# Dual-Format Host Command Port

This block is the slave side of a link to an external microcontroller. The host hands over 16-bit command words and collects 16-bit result words. A static mode pin picks the physical format. In serial format each direction has its own clock and data line. In parallel format an 8-bit bus carries one byte per strobe, and a byte-select line picks which byte. Both formats feed one command register and drain one result register, so the processor on the chip sees the same interface whichever format the board uses.

On the chip side a finished command sets a ready flag and gives a one-cycle interrupt pulse. The flag holds until the processor takes the word. The processor loads a result, and the active-low handshake line then goes low. It goes high again once the host has fetched the whole word. The same line therefore tells the host two things: a result is waiting, and it may send the next command when the line is high. All host lines pass through synchronizers, and their edges are detected in the system clock domain.

Top module: `hcp_port`

## Requirements
- R1: During and after synchronous reset, `dack_n` is high, `cmd_rdy` and `cmd_irq` are low, and both data-enable outputs `ser_rdat_oe` and `par_dout_oe` are low.
- R2: With `mode_serial` high, `ser_wdat` is sampled at each falling edge of `ser_wclk`, least significant bit first. Four clock edges after the sixteenth falling edge, `cmd_word` holds the word, `cmd_rdy` is high and `cmd_irq` pulses high for exactly one cycle.
- R3: `cmd_take` high while `cmd_rdy` is high clears `cmd_rdy` at the next clock edge.
- R4: A host word that completes while `cmd_rdy` is still high is dropped: `cmd_word` keeps its value and `cmd_irq` does not pulse.
- R5: `res_load` while `dack_n` is high captures `res_word`, and `dack_n` goes low at the next edge. In serial mode `ser_rdat_oe` rises at that same edge, and `ser_rdat` then carries bit 0.
- R6: In serial mode, each falling edge of `ser_rclk` advances `ser_rdat` to the next higher bit. After the sixteenth falling edge, `ser_rdat_oe` falls three edges later and `dack_n` returns high four edges later.
- R7: `res_load` while `dack_n` is low has no effect: the pending result is delivered unchanged.
- R8: With `mode_serial` low, a `par_wr_n` strobe with `par_sel`=0 stores the low byte from `par_din`. A strobe with `par_sel`=1 supplies the high byte and completes the word. `cmd_rdy` rises four edges after that strobe's rising edge.
- R9: With `mode_serial` low and `par_rd_n` low, `par_dout_oe` is high and `par_dout` shows the result byte chosen by `par_sel` (0 low, 1 high). The rising edge of `par_rd_n` with `par_sel`=1 returns `dack_n` high four edges later. A low-byte read leaves `dack_n` low.
- R10: The lines of the format not selected are ignored. In parallel mode the serial clocks neither complete a command nor release a result, and `ser_rdat_oe` stays low. In serial mode the parallel strobes do the same, and `par_dout_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_serial | input | 1 | Format select: 1 serial, 0 parallel (static) |
| ser_wclk | input | 1 | Serial command clock from host |
| ser_wdat | input | 1 | Serial command data, LSB first |
| ser_rclk | input | 1 | Serial result clock from host |
| ser_rdat | output | 1 | Serial result data, LSB first |
| ser_rdat_oe | output | 1 | Drive enable for `ser_rdat` (pad tri-stated when low) |
| par_sel | input | SEL_W | Byte select: 0 low byte, 1 high byte |
| par_rd_n | input | 1 | Parallel read strobe, active low |
| par_wr_n | input | 1 | Parallel write strobe, active low |
| par_din | input | BYTE_W | Parallel byte from host |
| par_dout | output | BYTE_W | Parallel result byte to host |
| par_dout_oe | output | 1 | Drive enable for `par_dout` |
| cmd_word | output | WORD_W | Command register |
| cmd_rdy | output | 1 | Command waiting for the processor |
| cmd_irq | output | 1 | One-cycle pulse per accepted command |
| cmd_take | input | 1 | Processor has read the command |
| res_word | input | WORD_W | Result from the processor |
| res_load | input | 1 | Load `res_word` into the result register |
| dack_n | output | 1 | Low while a result is waiting for the host |

## Verification
A host line change is captured by two synchronizer stages and then one edge-history register. A command, a released result or a finished parallel read therefore shows up four system edges after the host edge. The next serial result bit and the output enables settle after three edges, and a result load acts after one. The bench drives every host edge just after a falling system edge and counts edges from there. Each delayed flag is checked at both of its edges: still idle one edge early, then set on time. This catches an extra or a missing register stage as well as a wrong value. The drop, ignore and isolation cases are judged at the ports after enough edges for any effect to have appeared.

// File: rtl/hcp_pkg.sv
package hcp_pkg;
  typedef enum logic {
    HOST_PARALLEL = 1'b0,
    HOST_SERIAL   = 1'b1
  } host_mode_e;
endpackage

// File: rtl/hcp_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous host lines.
module hcp_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= {STAGES{RST_VAL}};
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hcp_ser_rx.sv
// Serial command deserializer, LSB first, one bit per detected falling edge.
module hcp_ser_rx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         clk_fall,
  input  logic         dat,
  output logic         word_valid,
  output logic [W-1:0] word
);
  localparam int CW = $clog2(W);

  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      sh         <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (!en) begin
        cnt <= '0;
      end else if (clk_fall) begin
        sh <= {dat, sh[W-1:1]};
        if (cnt == CW'(W - 1)) begin
          cnt        <= '0;
          word_valid <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign word = sh;
endmodule

// File: rtl/hcp_ser_tx.sv
// Serial result serializer; bit 0 is presented on load, later bits after each falling edge.
module hcp_ser_tx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] word,
  input  logic         clk_fall,
  output logic         bit_out,
  output logic         oe,
  output logic         done
);
  localparam int CW = $clog2(W);

  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sh   <= '0;
      oe   <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        cnt <= '0;
        oe  <= 1'b0;
      end else if (load) begin
        sh  <= word;
        cnt <= '0;
        oe  <= 1'b1;
      end else if (oe && clk_fall) begin
        if (cnt == CW'(W - 1)) begin
          oe   <= 1'b0;
          done <= 1'b1;
        end else begin
          sh  <= {1'b0, sh[W-1:1]};
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign bit_out = sh[0];
endmodule

// File: rtl/hcp_par_if.sv
// Parallel byte-lane assembly for commands and byte selection for results.
module hcp_par_if #(
  parameter int  WORD_W = 16,
  parameter int  BYTE_W = 8,
  localparam int LANES  = WORD_W / BYTE_W,
  localparam int SEL_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_rise,
  input  logic              rd_rise,
  input  logic              rd_active,
  input  logic [SEL_W-1:0]  sel,
  input  logic [BYTE_W-1:0] din,
  input  logic [WORD_W-1:0] res_word,
  output logic              word_valid,
  output logic [WORD_W-1:0] word,
  output logic [BYTE_W-1:0] dout,
  output logic              doe,
  output logic              read_done
);
  localparam logic [SEL_W-1:0] TOP_LANE = SEL_W'(LANES - 1);

  logic [WORD_W-1:0] assembled;

  // Lower lanes are held until the top lane arrives and completes the word.
  for (genvar g = 0; g < LANES - 1; g++) begin : g_lane
    logic [BYTE_W-1:0] held;
    always_ff @(posedge clk) begin
      if (rst)                                      held <= '0;
      else if (en && wr_rise && sel == SEL_W'(g))   held <= din;
    end
    assign assembled[g*BYTE_W +: BYTE_W] = held;
  end
  assign assembled[WORD_W-1 -: BYTE_W] = din;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_valid <= 1'b0;
      word       <= '0;
      dout       <= '0;
      doe        <= 1'b0;
      read_done  <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (en && wr_rise && sel == TOP_LANE) begin
        word       <= assembled;
        word_valid <= 1'b1;
      end
      dout      <= res_word[sel*BYTE_W +: BYTE_W];
      doe       <= en && rd_active;
      read_done <= en && rd_rise && sel == TOP_LANE;
    end
  end
endmodule

// File: rtl/hcp_port.sv
module hcp_port
  import hcp_pkg::*;
#(
  parameter int  WORD_W      = 16,
  parameter int  BYTE_W      = 8,
  parameter int  SYNC_STAGES = 2,
  localparam int LANES       = WORD_W / BYTE_W,
  localparam int SEL_W       = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_serial,
  input  logic              ser_wclk,
  input  logic              ser_wdat,
  input  logic              ser_rclk,
  output logic              ser_rdat,
  output logic              ser_rdat_oe,
  input  logic [SEL_W-1:0]  par_sel,
  input  logic              par_rd_n,
  input  logic              par_wr_n,
  input  logic [BYTE_W-1:0] par_din,
  output logic [BYTE_W-1:0] par_dout,
  output logic              par_dout_oe,
  output logic [WORD_W-1:0] cmd_word,
  output logic              cmd_rdy,
  output logic              cmd_irq,
  input  logic              cmd_take,
  input  logic [WORD_W-1:0] res_word,
  input  logic              res_load,
  output logic              dack_n
);
  localparam int PW = 2 + SEL_W + BYTE_W;

  // Synchronized host lines
  logic              mode_s;
  logic [2:0]        ser_s;
  logic [PW-1:0]     par_s;
  host_mode_e        mode_q;
  logic              ser_en, par_en;

  hcp_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_mode (
    .clk(clk), .rst(rst), .d(mode_serial), .q(mode_s));

  hcp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_sync_ser (
    .clk(clk), .rst(rst), .d({ser_rclk, ser_wdat, ser_wclk}), .q(ser_s));

  hcp_sync #(.W(PW), .STAGES(SYNC_STAGES),
             .RST_VAL({2'b11, {(SEL_W + BYTE_W){1'b0}}})) u_sync_par (
    .clk(clk), .rst(rst), .d({par_wr_n, par_rd_n, par_sel, par_din}), .q(par_s));

  assign mode_q = host_mode_e'(mode_s);
  assign ser_en = (mode_q == HOST_SERIAL);
  assign par_en = (mode_q == HOST_PARALLEL);

  logic              wclk_s, wdat_s, rclk_s;
  logic              wr_s, rd_s;
  logic [SEL_W-1:0]  sel_s;
  logic [BYTE_W-1:0] din_s;

  assign wclk_s = ser_s[0];
  assign wdat_s = ser_s[1];
  assign rclk_s = ser_s[2];
  assign wr_s   = par_s[PW-1];
  assign rd_s   = par_s[PW-2];
  assign sel_s  = par_s[BYTE_W +: SEL_W];
  assign din_s  = par_s[BYTE_W-1:0];

  // Edge history in the system domain
  logic wclk_d, rclk_d, wr_d, rd_d;
  always_ff @(posedge clk) begin
    if (rst) begin
      wclk_d <= 1'b0;
      rclk_d <= 1'b0;
      wr_d   <= 1'b1;
      rd_d   <= 1'b1;
    end else begin
      wclk_d <= wclk_s;
      rclk_d <= rclk_s;
      wr_d   <= wr_s;
      rd_d   <= rd_s;
    end
  end

  logic wclk_fall, rclk_fall, wr_rise, rd_rise;
  assign wclk_fall = wclk_d & ~wclk_s;
  assign rclk_fall = rclk_d & ~rclk_s;
  assign wr_rise   = ~wr_d & wr_s;
  assign rd_rise   = ~rd_d & rd_s;

  // Format engines
  logic              rx_valid, pw_valid, tx_done, pr_done, tx_load;
  logic [WORD_W-1:0] rx_word, pw_word, res_q;

  hcp_ser_rx #(.W(WORD_W)) u_ser_rx (
    .clk(clk), .rst(rst), .en(ser_en), .clk_fall(wclk_fall), .dat(wdat_s),
    .word_valid(rx_valid), .word(rx_word));

  assign tx_load = res_load & dack_n & ser_en;

  hcp_ser_tx #(.W(WORD_W)) u_ser_tx (
    .clk(clk), .rst(rst), .en(ser_en), .load(tx_load), .word(res_word),
    .clk_fall(rclk_fall), .bit_out(ser_rdat), .oe(ser_rdat_oe), .done(tx_done));

  hcp_par_if #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_par_if (
    .clk(clk), .rst(rst), .en(par_en), .wr_rise(wr_rise), .rd_rise(rd_rise),
    .rd_active(~rd_s), .sel(sel_s), .din(din_s), .res_word(res_q),
    .word_valid(pw_valid), .word(pw_word), .dout(par_dout), .doe(par_dout_oe),
    .read_done(pr_done));

  // Command register
  logic              host_word_valid;
  logic [WORD_W-1:0] host_word;
  assign host_word_valid = rx_valid | pw_valid;
  assign host_word       = rx_valid ? rx_word : pw_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_word <= '0;
      cmd_rdy  <= 1'b0;
      cmd_irq  <= 1'b0;
    end else begin
      cmd_irq <= 1'b0;
      if (cmd_take) cmd_rdy <= 1'b0;
      if (host_word_valid && !cmd_rdy) begin
        cmd_word <= host_word;
        cmd_rdy  <= 1'b1;
        cmd_irq  <= 1'b1;
      end
    end
  end

  // Result register and handshake
  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      dack_n <= 1'b1;
    end else if (res_load && dack_n) begin
      res_q  <= res_word;
      dack_n <= 1'b0;
    end else if ((tx_done || pr_done) && !dack_n) begin
      dack_n <= 1'b1;
    end
  end
endmodule

// File: rtl/hcp_port_chk.sv
module hcp_port_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] cmd_word,
  input logic              cmd_rdy,
  input logic              cmd_irq,
  input logic              cmd_take,
  input logic              res_load,
  input logic              dack_n,
  input logic              ser_rdat_oe,
  input logic              par_dout_oe
);
  // R1
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (dack_n && !cmd_rdy && !cmd_irq && !ser_rdat_oe && !par_dout_oe));

  // R2
  p_irq_single_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_irq |=> !cmd_irq);

  // R2
  p_irq_with_rdy_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_irq |-> cmd_rdy);

  // R3
  p_take_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_take && cmd_rdy) |=> !cmd_rdy);

  // R4
  p_word_held_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_rdy && !cmd_take) |=> ($stable(cmd_word) && !cmd_irq));

  // R5
  p_load_pends_r5: assert property (@(posedge clk) disable iff (rst)
    (res_load && dack_n) |=> !dack_n);

  // R6
  p_oe_only_pending_r6: assert property (@(posedge clk) disable iff (rst)
    ser_rdat_oe |-> !dack_n);

  // R10
  p_one_format_r10: assert property (@(posedge clk) disable iff (rst)
    !(ser_rdat_oe && par_dout_oe));
endmodule

bind hcp_port hcp_port_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_word(cmd_word), .cmd_rdy(cmd_rdy),
  .cmd_irq(cmd_irq), .cmd_take(cmd_take), .res_load(res_load),
  .dack_n(dack_n), .ser_rdat_oe(ser_rdat_oe), .par_dout_oe(par_dout_oe));

// File: tb/sim_hcp_port.sv
`timescale 1ns/1ps
module sim_hcp_port;
  logic        clk = 1'b0;
  logic        rst;
  logic        mode_serial;
  logic        ser_wclk, ser_wdat, ser_rclk;
  logic        ser_rdat, ser_rdat_oe;
  logic [0:0]  par_sel;
  logic        par_rd_n, par_wr_n;
  logic [7:0]  par_din, par_dout;
  logic        par_dout_oe;
  logic [15:0] cmd_word;
  logic        cmd_rdy, cmd_irq, cmd_take;
  logic [15:0] res_word;
  logic        res_load;
  logic        dack_n;

  int n_chk  = 0;
  int n_fail = 0;
  int irq_seen = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hcp_port u0 (
    .clk(clk), .rst(rst), .mode_serial(mode_serial),
    .ser_wclk(ser_wclk), .ser_wdat(ser_wdat), .ser_rclk(ser_rclk),
    .ser_rdat(ser_rdat), .ser_rdat_oe(ser_rdat_oe),
    .par_sel(par_sel), .par_rd_n(par_rd_n), .par_wr_n(par_wr_n),
    .par_din(par_din), .par_dout(par_dout), .par_dout_oe(par_dout_oe),
    .cmd_word(cmd_word), .cmd_rdy(cmd_rdy), .cmd_irq(cmd_irq), .cmd_take(cmd_take),
    .res_word(res_word), .res_load(res_load), .dack_n(dack_n));

  always @(negedge clk) if (!rst && cmd_irq) irq_seen++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic m);
    mode_serial = m;
    tick(4);
  endtask

  task automatic ser_send(input logic [15:0] w);
    for (int i = 0; i < 16; i++) begin
      ser_wdat = w[i];
      ser_wclk = 1'b1;
      tick(4);
      ser_wclk = 1'b0;
      if (i < 15) tick(4);
    end
  endtask

  task automatic take_cmd();
    cmd_take = 1'b1;
    tick(1);
    cmd_take = 1'b0;
  endtask

  task automatic res_push(input logic [15:0] w);
    res_word = w;
    res_load = 1'b1;
    tick(1);
    res_load = 1'b0;
  endtask

  task automatic ser_clock_out(input logic [15:0] w);
    for (int i = 0; i < 16; i++) begin
      chk($sformatf("R6 serial result bit %0d", i), {31'd0, ser_rdat}, {31'd0, w[i]});
      ser_rclk = 1'b1;
      tick(4);
      ser_rclk = 1'b0;
      if (i < 15) tick(4);
    end
    tick(3);
    chk("R6 rdat enable off 3 edges after last fall", {31'd0, ser_rdat_oe}, 32'd0);
    chk("R6 dack still low 3 edges after last fall", {31'd0, dack_n}, 32'd0);
    tick(1);
    chk("R6 dack high 4 edges after last fall", {31'd0, dack_n}, 32'd1);
  endtask

  task automatic par_write(input logic s, input logic [7:0] b);
    par_sel  = s;
    par_din  = b;
    par_wr_n = 1'b0;
    tick(4);
    par_wr_n = 1'b1;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst = 1'b1;
    tick(3);
    chk("R1 dack_n in reset", {31'd0, dack_n}, 32'd1);
    rst = 1'b0;
    tick(1);
    chk("R1 dack_n after reset", {31'd0, dack_n}, 32'd1);
    chk("R1 cmd_rdy after reset", {31'd0, cmd_rdy}, 32'd0);
    chk("R1 cmd_irq after reset", {31'd0, cmd_irq}, 32'd0);
    chk("R1 ser_rdat_oe after reset", {31'd0, ser_rdat_oe}, 32'd0);
    chk("R1 par_dout_oe after reset", {31'd0, par_dout_oe}, 32'd0);
  endtask

  task automatic t_ser_write(input logic [15:0] w);
    ser_send(w);
    tick(3);
    chk("R2 cmd_rdy not yet 3 edges after last fall", {31'd0, cmd_rdy}, 32'd0);
    tick(1);
    chk("R2 cmd_rdy 4 edges after last fall", {31'd0, cmd_rdy}, 32'd1);
    chk("R2 cmd_irq pulse", {31'd0, cmd_irq}, 32'd1);
    chk("R2 cmd_word LSB first", {16'd0, cmd_word}, {16'd0, w});
    tick(1);
    chk("R2 cmd_irq single cycle", {31'd0, cmd_irq}, 32'd0);
  endtask

  task automatic t_take();
    take_cmd();
    chk("R3 cmd_rdy cleared by take", {31'd0, cmd_rdy}, 32'd0);
  endtask

  task automatic t_drop();
    int irq_before;
    ser_send(16'h1234);
    tick(5);
    chk("R4 first word accepted", {16'd0, cmd_word}, 32'h1234);
    irq_before = irq_seen;
    ser_send(16'hFFFF);
    tick(6);
    chk("R4 word kept while ready", {16'd0, cmd_word}, 32'h1234);
    chk("R4 no irq for dropped word", irq_seen, irq_before);
    chk("R4 ready still set", {31'd0, cmd_rdy}, 32'd1);
    take_cmd();
  endtask

  task automatic t_ser_read(input logic [15:0] w, input bit try_overwrite);
    res_push(w);
    chk("R5 dack low one edge after load", {31'd0, dack_n}, 32'd0);
    chk("R5 rdat enabled on load", {31'd0, ser_rdat_oe}, 32'd1);
    chk("R5 bit 0 presented on load", {31'd0, ser_rdat}, {31'd0, w[0]});
    if (try_overwrite) begin
      res_push(~w);
      chk("R7 dack stays low on second load", {31'd0, dack_n}, 32'd0);
      chk("R7 bit 0 unchanged by second load", {31'd0, ser_rdat}, {31'd0, w[0]});
    end
    ser_clock_out(w);
  endtask

  task automatic t_par_write(input logic [15:0] w);
    par_write(1'b0, w[7:0]);
    tick(6);
    chk("R8 low byte alone does not complete", {31'd0, cmd_rdy}, 32'd0);
    par_write(1'b1, w[15:8]);
    tick(3);
    chk("R8 cmd_rdy not yet 3 edges after strobe", {31'd0, cmd_rdy}, 32'd0);
    tick(1);
    chk("R8 cmd_rdy 4 edges after strobe", {31'd0, cmd_rdy}, 32'd1);
    chk("R8 assembled word", {16'd0, cmd_word}, {16'd0, w});
    take_cmd();
  endtask

  task automatic t_par_read(input logic [15:0] w);
    res_push(w);
    chk("R5 dack low after load (parallel)", {31'd0, dack_n}, 32'd0);
    par_sel  = 1'b0;
    par_rd_n = 1'b0;
    tick(4);
    chk("R9 dout enabled during read", {31'd0, par_dout_oe}, 32'd1);
    chk("R9 low byte", {24'd0, par_dout}, {24'd0, w[7:0]});
    par_rd_n = 1'b1;
    tick(6);
    chk("R9 low-byte read keeps dack low", {31'd0, dack_n}, 32'd0);
    chk("R9 dout enable off after strobe", {31'd0, par_dout_oe}, 32'd0);
    par_sel  = 1'b1;
    par_rd_n = 1'b0;
    tick(4);
    chk("R9 high byte", {24'd0, par_dout}, {24'd0, w[15:8]});
    par_rd_n = 1'b1;
    tick(3);
    chk("R9 dack low 3 edges after high read", {31'd0, dack_n}, 32'd0);
    tick(1);
    chk("R9 dack high 4 edges after high read", {31'd0, dack_n}, 32'd1);
  endtask

  task automatic t_iso_parallel_mode();
    ser_send(16'h5AA5);
    tick(6);
    chk("R10 serial write ignored in parallel mode", {31'd0, cmd_rdy}, 32'd0);
    res_push(16'h0F0F);
    for (int i = 0; i < 16; i++) begin
      ser_rclk = 1'b1; tick(4);
      ser_rclk = 1'b0; tick(4);
    end
    tick(2);
    chk("R10 serial read clocks ignored in parallel mode", {31'd0, dack_n}, 32'd0);
    chk("R10 ser_rdat_oe low in parallel mode", {31'd0, ser_rdat_oe}, 32'd0);
    par_sel = 1'b1; par_rd_n = 1'b0; tick(4);
    par_rd_n = 1'b1; tick(6);
    chk("R9 pending result drained by parallel read", {31'd0, dack_n}, 32'd1);
  endtask

  task automatic t_iso_serial_mode();
    par_write(1'b0, 8'h11);
    tick(4);
    par_write(1'b1, 8'h22);
    tick(6);
    chk("R10 parallel write ignored in serial mode", {31'd0, cmd_rdy}, 32'd0);
    res_push(16'hB00D);
    par_sel  = 1'b1;
    par_rd_n = 1'b0;
    tick(4);
    chk("R10 par_dout_oe low in serial mode", {31'd0, par_dout_oe}, 32'd0);
    par_rd_n = 1'b1;
    tick(6);
    chk("R10 parallel read ignored in serial mode", {31'd0, dack_n}, 32'd0);
    ser_clock_out(16'hB00D);
  endtask

  initial begin
    rst = 1'b1; mode_serial = 1'b1;
    ser_wclk = 1'b0; ser_wdat = 1'b0; ser_rclk = 1'b0;
    par_sel = 1'b0; par_rd_n = 1'b1; par_wr_n = 1'b1; par_din = 8'h00;
    cmd_take = 1'b0; res_word = 16'h0000; res_load = 1'b0;
    tick(2);
    t_reset();
    tick(4);
    t_ser_write(16'hA5C3);
    t_take();
    t_ser_write(16'h8001);
    t_take();
    t_drop();
    t_ser_read(16'h8E31, 1'b1);
    t_ser_read(16'h7FFE, 1'b0);
    set_mode(1'b0);
    t_par_write(16'h7E81);
    t_par_write(16'h00FF);
    t_par_read(16'hC35A);
    t_iso_parallel_mode();
    set_mode(1'b1);
    t_iso_serial_mode();
    tick(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule